// File: doc/BRIEF.md
# Fixed-OR Product-Term Logic Block

A configurable combinational logic block for a 20-pin-style I/O arrangement. There are ten dedicated input pins, six bidirectional pins and two output-only pins. A programmable AND plane of 64 product terms sees sixteen variables, each in true and complemented form. The OR grouping behind the AND plane is hard-wired. Every one of the eight outputs owns eight consecutive product terms. Seven of them are summed by a fixed OR gate, and the result is inverted to give an active-low data value. The remaining term gates that output's tristate driver.

A bidirectional pin that is released acts as an extra input to the array. A pin that is driven feeds its own driven value back into the array. The tristate pins are modelled as separate data, enable and pin-input signals. Configuration is loaded one product-term row per clock through a simple write port, and an asynchronous reset clears every row.

Top module: `pt_logic_block`

## Requirements
- R1: While `rst_ni` is low, every configuration bit is cleared. With a cleared configuration, every enable is 1 and every data output is 0.
- R2: At a rising clock edge with `cfg_we_i` high, `cfg_wdata_i` replaces row `cfg_addr_i`, and all other rows are unchanged. With `cfg_we_i` low, no row changes.
- R3: In a row, bit 2v connects variable v true and bit 2v+1 connects its complement. A term is the AND of its connected literals. A row with no bits set yields 1. A row holding both literals of one variable yields 0.
- R4: Variables 0 to 9 are `in_i[0]` to `in_i[9]`. Variables 10 to 15 are the array values of bidirectional pins 0 to 5.
- R5: Output o owns rows 8o to 8o+7. Outputs 0 to 5 are bidirectional pins 0 to 5, and outputs 6 and 7 are `out_o[0]` and `out_o[1]`.
- R6: The data value of output o is the inverse of the OR of its rows 8o+1 to 8o+7.
- R7: The enable of output o equals row 8o. The data value is presented whatever the enable is.
- R8: A bidirectional pin whose first-pass enable is 0 gives the array the value on `pin_i` for that pin.
- R9: Evaluation runs in two passes. The first pass uses `pin_i` for all six pin variables. In the second pass, a pin whose first-pass enable is 1 gives the array its first-pass data value. All outputs come from the second pass.
- R10: The outputs follow the inputs combinationally. A row write takes effect in the outputs right after the writing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for configuration writes |
| rst_ni | input | 1 | Active-low asynchronous reset, clears configuration |
| cfg_we_i | input | 1 | Row write strobe |
| cfg_addr_i | input | 6 | Product-term row index |
| cfg_wdata_i | input | 32 | Literal connection bits for the row |
| in_i | input | 10 | Dedicated inputs |
| pin_i | input | 6 | Values seen on the bidirectional pins |
| pin_o | output | 6 | Data driven to the bidirectional pins |
| pin_oe_o | output | 6 | Driver enables of the bidirectional pins |
| out_o | output | 2 | Data of the output-only pins |
| out_oe_o | output | 2 | Driver enables of the output-only pins |

## Verification
A corrupted configuration row shows up at once, with no clock delay, on the single output that owns it. It appears as soon as the inputs set the literals that row selects. A row no input pattern can reach stays invisible unless the random patterns hit it. A feedback fault shows only when the affected pin is enabled while `pin_i` disagrees with its driven value. For that reason the stimulus drives the pins against their own outputs in both driven and released states.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
  localparam int unsigned DEF_NUM_IN        = 10;
  localparam int unsigned DEF_NUM_BIDIR     = 6;
  localparam int unsigned DEF_NUM_DED       = 2;
  localparam int unsigned DEF_TERMS_PER_OUT = 8;
  localparam int unsigned DEF_SETTLE_PASSES = 2;

  // slot 0 is the enable term, slots 1.. feed the fixed OR
  function automatic int unsigned row_of(int unsigned out_idx, int unsigned slot,
                                         int unsigned terms_per_out);
    return out_idx * terms_per_out + slot;
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
module pla_cfg_store #(
  parameter int unsigned NUM_TERMS = 64,
  parameter int unsigned NUM_LIT   = 32,
  localparam int unsigned ADDR_W   = $clog2(NUM_TERMS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NUM_LIT-1:0]           wdata_i,
  output logic [NUM_TERMS*NUM_LIT-1:0] cfg_o
);
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_row
    logic [NUM_LIT-1:0] row_q;
    logic               hit;

    assign hit = we_i && (addr_i == ADDR_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  row_q <= '0;
      else if (hit) row_q <= wdata_i;
    end

    assign cfg_o[t*NUM_LIT +: NUM_LIT] = row_q;

    a_r1_reset_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (cfg_o[t*NUM_LIT +: NUM_LIT] == '0));
    a_r2_row_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(t)) |=> (cfg_o[t*NUM_LIT +: NUM_LIT] == $past(wdata_i)));
    a_r2_row_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == ADDR_W'(t)) |=> $stable(cfg_o[t*NUM_LIT +: NUM_LIT]));
  end
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int unsigned NUM_VAR   = 16,
  parameter int unsigned NUM_TERMS = 64,
  localparam int unsigned NUM_LIT  = 2 * NUM_VAR
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_VAR-1:0]           var_i,
  input  logic [NUM_TERMS*NUM_LIT-1:0] cfg_i,
  output logic [NUM_TERMS-1:0]         term_o
);
  logic [NUM_LIT-1:0] lits;

  always_comb begin
    for (int v = 0; v < NUM_VAR; v++) begin
      lits[2*v]   = var_i[v];
      lits[2*v+1] = ~var_i[v];
    end
  end

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    // unconnected literal positions are forced true
    assign term_o[t] = &(~cfg_i[t*NUM_LIT +: NUM_LIT] | lits);

    a_r3_blank_term_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[t*NUM_LIT +: NUM_LIT] == '0) |-> term_o[t]);
    a_r3_contra_term_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[t*NUM_LIT] && cfg_i[t*NUM_LIT+1]) |-> !term_o[t]);
  end
endmodule

// File: rtl/pla_or_fixed.sv
`timescale 1ns/1ps
module pla_or_fixed #(
  parameter int unsigned NUM_OUT       = 8,
  parameter int unsigned TERMS_PER_OUT = 8,
  localparam int unsigned NUM_TERMS    = NUM_OUT * TERMS_PER_OUT,
  localparam int unsigned SUM_W        = TERMS_PER_OUT - 1
) (
  input  logic [NUM_TERMS-1:0] term_i,
  output logic [NUM_OUT-1:0]   data_o,
  output logic [NUM_OUT-1:0]   oe_o
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    assign oe_o[o]   = term_i[o*TERMS_PER_OUT];
    assign data_o[o] = ~|term_i[o*TERMS_PER_OUT+1 +: SUM_W];
  end
endmodule

// File: rtl/pt_logic_block.sv
`timescale 1ns/1ps
module pt_logic_block #(
  parameter int unsigned NUM_IN        = pla_pkg::DEF_NUM_IN,
  parameter int unsigned NUM_BIDIR     = pla_pkg::DEF_NUM_BIDIR,
  parameter int unsigned NUM_DED       = pla_pkg::DEF_NUM_DED,
  parameter int unsigned TERMS_PER_OUT = pla_pkg::DEF_TERMS_PER_OUT,
  parameter int unsigned SETTLE_PASSES = pla_pkg::DEF_SETTLE_PASSES,
  localparam int unsigned NUM_VAR      = NUM_IN + NUM_BIDIR,
  localparam int unsigned NUM_LIT      = 2 * NUM_VAR,
  localparam int unsigned NUM_OUT      = NUM_BIDIR + NUM_DED,
  localparam int unsigned NUM_TERMS    = NUM_OUT * TERMS_PER_OUT,
  localparam int unsigned ADDR_W       = $clog2(NUM_TERMS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [NUM_LIT-1:0]   cfg_wdata_i,
  input  logic [NUM_IN-1:0]    in_i,
  input  logic [NUM_BIDIR-1:0] pin_i,
  output logic [NUM_BIDIR-1:0] pin_o,
  output logic [NUM_BIDIR-1:0] pin_oe_o,
  output logic [NUM_DED-1:0]   out_o,
  output logic [NUM_DED-1:0]   out_oe_o
);
  localparam int unsigned LAST  = SETTLE_PASSES - 1;
  localparam int unsigned SUM_W = TERMS_PER_OUT - 1;

  logic [NUM_TERMS*NUM_LIT-1:0] cfg;
  logic [NUM_VAR-1:0]           var_p  [SETTLE_PASSES];
  logic [NUM_TERMS-1:0]         term_p [SETTLE_PASSES];
  logic [NUM_OUT-1:0]           data_p [SETTLE_PASSES];
  logic [NUM_OUT-1:0]           oe_p   [SETTLE_PASSES];

  pla_cfg_store #(
    .NUM_TERMS (NUM_TERMS),
    .NUM_LIT   (NUM_LIT)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  // pass 0 reads the pins as seen; later passes substitute driven values
  for (genvar p = 0; p < SETTLE_PASSES; p++) begin : g_pass
    if (p == 0) begin : g_first
      assign var_p[p] = {pin_i, in_i};
    end else begin : g_next
      logic [NUM_BIDIR-1:0] fb;
      always_comb begin
        for (int k = 0; k < NUM_BIDIR; k++)
          fb[k] = oe_p[p-1][k] ? data_p[p-1][k] : pin_i[k];
      end
      assign var_p[p] = {fb, in_i};
    end

    pla_and_plane #(
      .NUM_VAR   (NUM_VAR),
      .NUM_TERMS (NUM_TERMS)
    ) u_and (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .var_i  (var_p[p]),
      .cfg_i  (cfg),
      .term_o (term_p[p])
    );

    pla_or_fixed #(
      .NUM_OUT       (NUM_OUT),
      .TERMS_PER_OUT (TERMS_PER_OUT)
    ) u_or (
      .term_i (term_p[p]),
      .data_o (data_p[p]),
      .oe_o   (oe_p[p])
    );
  end

  assign pin_o    = data_p[LAST][NUM_BIDIR-1:0];
  assign pin_oe_o = oe_p[LAST][NUM_BIDIR-1:0];
  assign out_o    = data_p[LAST][NUM_OUT-1:NUM_BIDIR];
  assign out_oe_o = oe_p[LAST][NUM_OUT-1:NUM_BIDIR];

  a_r8_released_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_p[0][NUM_BIDIR-1:0] == '0) |-> (term_p[LAST] == term_p[0]));

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    localparam int unsigned EN_ROW  = pla_pkg::row_of(o, 0, TERMS_PER_OUT);
    localparam int unsigned SUM_ROW = pla_pkg::row_of(o, 1, TERMS_PER_OUT);

    a_r6_blank_sum_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg[SUM_ROW*NUM_LIT +: SUM_W*NUM_LIT] == '0) |-> !data_p[LAST][o]);
    a_r7_blank_enable_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg[EN_ROW*NUM_LIT +: NUM_LIT] == '0) |-> oe_p[LAST][o]);
  end
endmodule

// File: tb/sim_pt_logic_block.sv
`timescale 1ns/1ps
module sim_pt_logic_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [9:0]  din = '0;
  logic [5:0]  pin = '0;
  logic [5:0]  pin_d, pin_oe;
  logic [1:0]  dout, dout_oe;

  logic [31:0] mcfg [64];
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pt_logic_block u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .in_i(din), .pin_i(pin), .pin_o(pin_d),
    .pin_oe_o(pin_oe), .out_o(dout), .out_oe_o(dout_oe)
  );

  function automatic logic [63:0] eval_terms(input logic [15:0] v);
    logic [63:0] t;
    for (int r = 0; r < 64; r++) begin
      t[r] = 1'b1;
      for (int b = 0; b < 32; b++)
        if (mcfg[r][b]) t[r] = t[r] & ((b % 2 == 1) ? ~v[b/2] : v[b/2]);
    end
    return t;
  endfunction

  // returns {enables[7:0], data[7:0]}
  function automatic logic [15:0] model(input logic [9:0] di, input logic [5:0] pi);
    logic [63:0] ta, tb;
    logic [5:0]  fb;
    logic [7:0]  d, oe;
    ta = eval_terms({pi, di});
    for (int k = 0; k < 6; k++) fb[k] = ta[8*k] ? ~|ta[8*k+1 +: 7] : pi[k];
    tb = eval_terms({fb, di});
    for (int o = 0; o < 8; o++) begin
      oe[o] = tb[8*o];
      d[o]  = ~|tb[8*o+1 +: 7];
    end
    return {oe, d};
  endfunction

  task automatic check(input string tag);
    logic [15:0] exp, act;
    #1;
    exp = model(din, pin);
    act = {dout_oe, pin_oe, dout, pin_d};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (in=%h pin=%h)", tag, act, exp, din, pin);
    end
  endtask

  task automatic apply(input logic [9:0] di, input logic [5:0] pi, input string tag);
    @(negedge clk);
    din = di;
    pin = pi;
    check(tag);
  endtask

  task automatic wr(input int r, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = r[5:0]; wdata = d;
    @(posedge clk);
    mcfg[r] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] rand_row(input bit enable_row);
    logic [31:0] r;
    if (enable_row && ($urandom_range(0, 2) == 0)) return '0;
    for (int b = 0; b < 32; b++) r[b] = ($urandom_range(0, 9) == 0);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 64; r++) mcfg[r] = '0;
    repeat (3) @(posedge clk);
    apply(10'h155, 6'h2a, "R1 blank outputs during reset");
    @(negedge clk) rst_n = 1'b1;
    apply(10'h3ff, 6'h3f, "R1 blank configuration after reset");
    apply(10'h000, 6'h00, "R1 blank configuration all-zero inputs");

    // out_o[0] owns rows 48..55; rows 50..55 forced to constant 0
    for (int r = 50; r < 56; r++) wr(r, 32'h3);
    wr(49, 32'h1);
    apply(10'h000, 6'h00, "R3 true literal in0=0, R10 write visible");
    apply(10'h001, 6'h00, "R3 true literal in0=1");
    wr(49, 32'h2);
    apply(10'h000, 6'h00, "R3 complement literal in0=0");
    apply(10'h001, 6'h00, "R3 complement literal in0=1");
    wr(49, 32'h3);
    apply(10'h3ff, 6'h3f, "R3 contradiction gives 0, R6 output high");
    wr(49, 32'h0);
    apply(10'h2aa, 6'h15, "R3 blank term gives 1, R6 output low");

    // pin 2 released via contradictory enable row; out_o[0] reads variable 12
    wr(16, 32'h3);
    wr(49, 32'h1 << 24);
    apply(10'h000, 6'h00, "R4 R8 released pin2 low");
    apply(10'h000, 6'h04, "R4 R8 released pin2 high");
    wr(49, 32'h1 << 18);
    apply(10'h200, 6'h00, "R4 dedicated in9 high");
    apply(10'h000, 6'h00, "R4 dedicated in9 low");

    // write strobe low: row 49 must keep variable 9 connection
    @(negedge clk);
    addr = 6'd49; wdata = 32'h0; we = 1'b0;
    @(posedge clk);
    apply(10'h200, 6'h00, "R2 no write with strobe low");
    apply(10'h000, 6'h00, "R2 row kept with strobe low");

    // pin0 enabled, data = ~in1; out_o[0] reads variable 10 (pin0 feedback)
    wr(0, 32'h0);
    wr(1, 32'h1 << 2);
    for (int r = 2; r < 8; r++) wr(r, 32'h3);
    wr(49, 32'h1 << 20);
    apply(10'h002, 6'h00, "R9 driven feedback against pin_i low");
    apply(10'h000, 6'h01, "R9 driven feedback against pin_i high");
    apply(10'h002, 6'h01, "R9 driven feedback matching pin_i");

    // pin0 enable follows in3
    wr(0, 32'h1 << 6);
    apply(10'h008, 6'h00, "R7 enable on via in3");
    apply(10'h000, 6'h01, "R7 R8 enable off, pin_i fed back");
    apply(10'h000, 6'h00, "R7 R8 enable off, pin_i low fed back");

    for (int c = 0; c < 20; c++) begin
      for (int r = 0; r < 64; r++) wr(r, rand_row(r % 8 == 0));
      apply(din, pin, "R10 outputs follow new configuration");
      for (int v = 0; v < 30; v++)
        apply(10'($urandom), 6'($urandom), "R5 R6 R7 R9 random pattern");
    end

    // reset clears a loaded configuration
    @(negedge clk) rst_n = 1'b0;
    for (int r = 0; r < 64; r++) mcfg[r] = '0;
    apply(10'h0f0, 6'h0f, "R1 reset clears loaded rows");
    @(negedge clk) rst_n = 1'b1;
    apply(10'h30f, 6'h30, "R1 blank after second reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule